// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register file and command decoder for a two-channel asynchronous serial controller. A processor reaches it through a 4-bit address, an 8-bit write data bus, an 8-bit read data bus and separate read and write strobes. Each strobe counts as one access on the rising clock edge at which it is high. Read data is combinational from the address and the current state. Several addresses lead to one register when read and to a different register when written. Some addresses do no storage at all and act as commands when accessed.

The bit serializers, the baud-rate generator and the counter/timer datapath sit outside the block. They report their state through level inputs, sticky event pulses and a count value. In return the block drives mode, clock-select, auxiliary and output-port fields, enable and break levels, and one-cycle strobes. It also raises a single interrupt request, formed from a status vector and a mask.

Top module: `uart_fe`

## Requirements
- R1: After a synchronous active-low reset, every stored register reads zero except the interrupt vector, which reads 0x0F. Both mode pointers select mode register 1, and the interrupt request is low.
- R2: A channel's two mode registers share offset 0. While the pointer selects mode register 1, a read or a write there reaches mode register 1 and moves the pointer to mode register 2. The pointer then stays on mode register 2 until a command write with value 1 in bits [6:4] returns it to mode register 1.
- R3: At offset 1, a read returns channel status and a write loads the clock-select register. At offset 3, a write latches the transmit character and gives a one-cycle load strobe. A read at offset 3 returns the receive character and gives a one-cycle pop strobe.
- R4: In a command write, bit 2 enables the transmitter and bit 3 disables it. Bit 0 enables the receiver and bit 1 disables it. Each enable is held as a level, and if both bits of a pair are 1 the disable wins.
- R5: Command value 2 in bits [6:4] gives a one-cycle receiver-reset strobe, and value 3 gives a one-cycle transmitter-reset strobe. Value 6 raises the channel's break output and value 7 lowers it.
- R6: The status byte holds sticky received-break in bit 7, framing in bit 6, parity in bit 5 and overrun in bit 4. The live levels fill the low bits: transmitter empty in bit 3, transmitter ready in bit 2, receive FIFO full in bit 1 and receiver ready in bit 0. Command value 4 clears the four sticky bits of that channel in one cycle.
- R7: Interrupt status, read at 0x5, has input change in bit 7 and counter/timer in bit 3. Channel B fills bits 6..4 and channel A fills bits 2..0, in the order break change, receiver ready, transmitter ready. The request is high when status AND the mask written at 0x5 is nonzero. Command value 5 clears the channel's break-change bit.
- R8: A write at 0xE sets each output port bit whose data bit is 1. A write at 0xF clears each such bit, and all other bits keep their values.
- R9: A read at 0xE gives a one-cycle counter start strobe. A read at 0xF gives a one-cycle stop strobe and clears the counter/timer status bit. Writes at 0x6 and 0x7 load the upper and lower preload bytes, and reads at those addresses return the upper and lower count bytes.
- R10: A read at 0x4 returns the change flags of input pins 3..0 in bits 7..4 and the live pins 3..0 in bits 3..0, and it clears the change flags. A read at 0xD returns the raw input pins.
- R11: The interrupt vector at 0xC can be read and written. A write at 0x4 loads the auxiliary control output, and a write at 0xD loads the output configuration output.
- R12: Channel B decodes offsets 0..3 at addresses 0x8..0xB and keeps its own state. An access to channel A leaves channel B unchanged, and an access to B leaves A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects on the clock edge) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| ch_lvl_i | input | 8 | Live channel levels {B[3:0],A[3:0]}: tx empty, tx ready, rx full, rx ready |
| ch_err_i | input | 8 | Error event pulses {B[3:0],A[3:0]}: break, framing, parity, overrun |
| ch_brkchg_i | input | 2 | Break-change event pulse per channel |
| rx_char_i | input | 16 | Received characters {B,A} |
| ct_done_i | input | 1 | Counter/timer terminal event pulse |
| ct_count_i | input | 16 | Current counter value |
| ip_i | input | 6 | Input port pins (already synchronized) |
| mode1_o | output | 16 | Mode register 1 per channel {B,A} |
| mode2_o | output | 16 | Mode register 2 per channel {B,A} |
| clksel_o | output | 16 | Clock-select per channel {B,A} |
| tx_en_o | output | 2 | Transmitter enable per channel |
| rx_en_o | output | 2 | Receiver enable per channel |
| brk_o | output | 2 | Break level per channel |
| tx_load_o | output | 2 | Transmit character load strobe per channel |
| tx_char_o | output | 16 | Latched transmit characters {B,A} |
| rx_pop_o | output | 2 | Receive character pop strobe per channel |
| rx_rst_o | output | 2 | Receiver reset strobe per channel |
| tx_rst_o | output | 2 | Transmitter reset strobe per channel |
| aux_ctl_o | output | 8 | Auxiliary control register |
| op_cfg_o | output | 8 | Output port configuration |
| op_o | output | 8 | Output port bits |
| ct_preload_o | output | 16 | Counter preload value |
| ct_start_o | output | 1 | Counter start strobe |
| ct_stop_o | output | 1 | Counter stop strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
A mode pointer that is stuck or wrong appears on the first offset-0 read after a pointer reset or after a first access, because the byte returned belongs to the other mode register. An enable, break or sticky error that is mis-held is visible on the enable and break outputs, or in the status byte, one clock after the command write. A mask or status bit that is wrong appears on the interrupt request in the same cycle as the register update. Every command strobe is registered, so each one is checked high exactly one cycle after its access and low again in the cycle after that.

// File: rtl/uart_fe_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial controller register front end.
// Assumes 8-bit data and a 4-bit address split into channel and shared halves.
package uart_fe_pkg;

    localparam int DW   = 8;          // register data width
    localparam int CT_W = 2 * DW;     // counter is two bytes wide

    // One-shot command codes carried in command bits [6:4]
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_PTR_RST = 3'd1,
        CMD_RX_RST  = 3'd2,
        CMD_TX_RST  = 3'd3,
        CMD_ERR_CLR = 3'd4,
        CMD_BRK_ACK = 3'd5,
        CMD_BRK_ON  = 3'd6,
        CMD_BRK_OFF = 3'd7
    } cmd_e;

    // Per-channel offsets (address bits [1:0])
    localparam logic [1:0] OFF_MODE = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd1;
    localparam logic [1:0] OFF_CMD  = 2'd2;
    localparam logic [1:0] OFF_BUF  = 2'd3;

    // Shared selectors formed as {addr[3], addr[1:0]}
    localparam logic [2:0] SH_CHG  = 3'd0;  // 0x4
    localparam logic [2:0] SH_INT  = 3'd1;  // 0x5
    localparam logic [2:0] SH_CHI  = 3'd2;  // 0x6
    localparam logic [2:0] SH_CLO  = 3'd3;  // 0x7
    localparam logic [2:0] SH_VEC  = 3'd4;  // 0xC
    localparam logic [2:0] SH_PIN  = 3'd5;  // 0xD
    localparam logic [2:0] SH_OSET = 3'd6;  // 0xE
    localparam logic [2:0] SH_OCLR = 3'd7;  // 0xF

    localparam logic [DW-1:0] VEC_RESET = 8'h0F;

endpackage

// File: rtl/uart_fe_chan.sv
`timescale 1ns/1ps
// One serial channel's registers: two mode registers behind a pointer,
// clock select, sticky error status, command decode with held enables and
// break, and registered one-cycle strobes.
// Assumes wr_i/rd_i are already qualified for this channel.
module uart_fe_chan
    import uart_fe_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [1:0]    off_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [3:0]    lvl_i,
    input  logic [3:0]    err_i,
    input  logic          brkchg_i,
    input  logic [DW-1:0] rx_char_i,
    output logic [DW-1:0] mr1_o,
    output logic [DW-1:0] mr2_o,
    output logic [DW-1:0] csr_o,
    output logic          tx_en_o,
    output logic          rx_en_o,
    output logic          brk_o,
    output logic          tx_load_o,
    output logic [DW-1:0] tx_char_o,
    output logic          rx_pop_o,
    output logic          rx_rst_o,
    output logic          tx_rst_o,
    output logic          brkchg_o,
    output logic [DW-1:0] rdata_o
);

    logic          ptr_q;
    logic [DW-1:0] mr1_q, mr2_q, csr_q, txc_q;
    logic [3:0]    err_q;
    logic          brkchg_q, tx_en_q, rx_en_q, brk_q;
    logic          tx_load_q, rx_pop_q, rx_rst_q, tx_rst_q;

    logic cmd_wr, mode_acc;
    cmd_e cmd;

    assign cmd_wr   = wr_i && (off_i == OFF_CMD);
    assign mode_acc = (wr_i || rd_i) && (off_i == OFF_MODE);
    assign cmd      = cmd_e'(wdata_i[6:4]);

    // Mode pointer: first access moves to MR2, pointer-reset command returns.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ptr_q <= 1'b0;
        else if (cmd_wr && cmd == CMD_PTR_RST)  ptr_q <= 1'b0;
        else if (mode_acc)                      ptr_q <= 1'b1;
    end

    // Mode and clock-select storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr1_q <= '0;
            mr2_q <= '0;
            csr_q <= '0;
        end else if (wr_i) begin
            if (off_i == OFF_MODE && !ptr_q) mr1_q <= wdata_i;
            if (off_i == OFF_MODE &&  ptr_q) mr2_q <= wdata_i;
            if (off_i == OFF_STAT)           csr_q <= wdata_i;
        end
    end

    // Sticky error and break-change flags with command clears (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q    <= '0;
            brkchg_q <= 1'b0;
        end else begin
            if (cmd_wr && cmd == CMD_ERR_CLR) err_q <= '0;
            else                              err_q <= err_q | err_i;
            if (cmd_wr && cmd == CMD_BRK_ACK) brkchg_q <= 1'b0;
            else if (brkchg_i)                brkchg_q <= 1'b1;
        end
    end

    // Held enables (disable beats enable) and break level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            brk_q   <= 1'b0;
        end else if (cmd_wr) begin
            if (wdata_i[3])      tx_en_q <= 1'b0;
            else if (wdata_i[2]) tx_en_q <= 1'b1;
            if (wdata_i[1])      rx_en_q <= 1'b0;
            else if (wdata_i[0]) rx_en_q <= 1'b1;
            if (cmd == CMD_BRK_ON)  brk_q <= 1'b1;
            if (cmd == CMD_BRK_OFF) brk_q <= 1'b0;
        end
    end

    // Registered one-cycle strobes and transmit character latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_load_q <= 1'b0;
            rx_pop_q  <= 1'b0;
            rx_rst_q  <= 1'b0;
            tx_rst_q  <= 1'b0;
            txc_q     <= '0;
        end else begin
            tx_load_q <= wr_i && (off_i == OFF_BUF);
            rx_pop_q  <= rd_i && (off_i == OFF_BUF);
            rx_rst_q  <= cmd_wr && (cmd == CMD_RX_RST);
            tx_rst_q  <= cmd_wr && (cmd == CMD_TX_RST);
            if (wr_i && off_i == OFF_BUF) txc_q <= wdata_i;
        end
    end

    // Read mux for this channel.
    always_comb begin
        case (off_i)
            OFF_MODE: rdata_o = ptr_q ? mr2_q : mr1_q;
            OFF_STAT: rdata_o = {err_q, lvl_i};
            OFF_BUF:  rdata_o = rx_char_i;
            default:  rdata_o = '0;
        endcase
    end

    assign mr1_o     = mr1_q;
    assign mr2_o     = mr2_q;
    assign csr_o     = csr_q;
    assign tx_en_o   = tx_en_q;
    assign rx_en_o   = rx_en_q;
    assign brk_o     = brk_q;
    assign tx_load_o = tx_load_q;
    assign tx_char_o = txc_q;
    assign rx_pop_o  = rx_pop_q;
    assign rx_rst_o  = rx_rst_q;
    assign tx_rst_o  = tx_rst_q;
    assign brkchg_o  = brkchg_q;

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q && !(cmd_wr && cmd == CMD_PTR_RST)) |=> ptr_q); // R2
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata_i[3]) |=> !tx_en_q); // R4
    AST_RXRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_q |-> $past(cmd_wr && cmd == CMD_RX_RST)); // R5
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd == CMD_ERR_CLR) |=> (err_q == 4'b0)); // R6

endmodule

// File: rtl/uart_fe_shared.sv
`timescale 1ns/1ps
// Registers shared by both channels: auxiliary control, interrupt status and
// mask, vector, output port and its configuration, counter preload and
// strobes, and input-pin change tracking.
// Assumes ip_i is synchronized and at least 4 pins wide.
module uart_fe_shared
    import uart_fe_pkg::*;
#(
    parameter int IP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [2:0]      sel_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [1:0]      txrdy_i,
    input  logic [1:0]      rxrdy_i,
    input  logic [1:0]      brkchg_i,
    input  logic            ct_done_i,
    input  logic [CT_W-1:0] ct_count_i,
    input  logic [IP_W-1:0] ip_i,
    output logic [DW-1:0]   acr_o,
    output logic [DW-1:0]   opcr_o,
    output logic [DW-1:0]   op_o,
    output logic [CT_W-1:0] preload_o,
    output logic            ct_start_o,
    output logic            ct_stop_o,
    output logic            irq_o,
    output logic [DW-1:0]   rdata_o
);

    localparam int CHG_W = 4;

    logic [DW-1:0]    acr_q, imr_q, ivr_q, opcr_q, op_q;
    logic [CT_W-1:0]  pre_q;
    logic             timer_q, start_q, stop_q;
    logic [CHG_W-1:0] chg_q, prev_q;
    logic [DW-1:0]    isr;

    logic rd_stop;
    assign rd_stop = rd_i && (sel_i == SH_OCLR);

    // Plain storage registers written by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acr_q  <= '0;
            imr_q  <= '0;
            ivr_q  <= VEC_RESET;
            opcr_q <= '0;
            pre_q  <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SH_CHG: acr_q  <= wdata_i;
                SH_INT: imr_q  <= wdata_i;
                SH_CHI: pre_q[CT_W-1 -: DW] <= wdata_i;
                SH_CLO: pre_q[DW-1:0]       <= wdata_i;
                SH_VEC: ivr_q  <= wdata_i;
                SH_PIN: opcr_q <= wdata_i;
                default: ;
            endcase
        end
    end

    // Output port bit set and bit clear commands.
    always_ff @(posedge clk) begin
        if (!rst_n)                           op_q <= '0;
        else if (wr_i && sel_i == SH_OSET)    op_q <= op_q | wdata_i;
        else if (wr_i && sel_i == SH_OCLR)    op_q <= op_q & ~wdata_i;
    end

    // Counter strobes on reads and timer status (stop read wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            timer_q <= 1'b0;
        end else begin
            start_q <= rd_i && (sel_i == SH_OSET);
            stop_q  <= rd_stop;
            if (rd_stop)        timer_q <= 1'b0;
            else if (ct_done_i) timer_q <= 1'b1;
        end
    end

    // Previous pin sample for change detection (refreshed every cycle).
    always_ff @(posedge clk) begin
        prev_q <= ip_i[CHG_W-1:0];
    end

    // Change flags: set on a pin edge, cleared by a read of the change register.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= '0;
        else chg_q <= (chg_q & ~{CHG_W{rd_i && sel_i == SH_CHG}})
                    | (ip_i[CHG_W-1:0] ^ prev_q);
    end

    assign isr = {|chg_q, brkchg_i[1], rxrdy_i[1], txrdy_i[1],
                  timer_q, brkchg_i[0], rxrdy_i[0], txrdy_i[0]};

    assign irq_o = |(isr & imr_q);

    // Read mux for the shared half of the map.
    always_comb begin
        case (sel_i)
            SH_CHG:  rdata_o = {chg_q, ip_i[CHG_W-1:0]};
            SH_INT:  rdata_o = isr;
            SH_CHI:  rdata_o = ct_count_i[CT_W-1 -: DW];
            SH_CLO:  rdata_o = ct_count_i[DW-1:0];
            SH_VEC:  rdata_o = ivr_q;
            SH_PIN:  rdata_o = {{(DW-IP_W){1'b0}}, ip_i};
            default: rdata_o = '0;
        endcase
    end

    assign acr_o      = acr_q;
    assign opcr_o     = opcr_q;
    assign op_o       = op_q;
    assign preload_o  = pre_q;
    assign ct_start_o = start_q;
    assign ct_stop_o  = stop_q;

    AST_OP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SH_OSET) |=> ((op_q & $past(wdata_i)) == $past(wdata_i))); // R8
    AST_OP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SH_OCLR) |=> ((op_q & $past(wdata_i)) == '0)); // R8
    AST_TIMER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stop |=> !timer_q); // R9
    AST_CHG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i == SH_CHG && $stable(ip_i)) |=> (chg_q == '0)); // R10

endmodule

// File: rtl/uart_fe.sv
`timescale 1ns/1ps
// Top of the two-channel serial controller register front end. Splits the
// 4-bit address into per-channel space (addr[2]==0, channel by addr[3]) and
// shared space, and muxes read data. Read data is combinational.
module uart_fe
    import uart_fe_pkg::*;
#(
    parameter int IP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      addr_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o,
    input  logic [7:0]      ch_lvl_i,
    input  logic [7:0]      ch_err_i,
    input  logic [1:0]      ch_brkchg_i,
    input  logic [15:0]     rx_char_i,
    input  logic            ct_done_i,
    input  logic [15:0]     ct_count_i,
    input  logic [IP_W-1:0] ip_i,
    output logic [15:0]     mode1_o,
    output logic [15:0]     mode2_o,
    output logic [15:0]     clksel_o,
    output logic [1:0]      tx_en_o,
    output logic [1:0]      rx_en_o,
    output logic [1:0]      brk_o,
    output logic [1:0]      tx_load_o,
    output logic [15:0]     tx_char_o,
    output logic [1:0]      rx_pop_o,
    output logic [1:0]      rx_rst_o,
    output logic [1:0]      tx_rst_o,
    output logic [7:0]      aux_ctl_o,
    output logic [7:0]      op_cfg_o,
    output logic [7:0]      op_o,
    output logic [15:0]     ct_preload_o,
    output logic            ct_start_o,
    output logic            ct_stop_o,
    output logic            irq_o
);

    localparam int NCH  = 2;
    localparam int LVLW = 4;

    logic          in_ch;
    logic [DW-1:0] ch_rdata [NCH];
    logic [DW-1:0] sh_rdata;
    logic [NCH-1:0] brkchg_q, txrdy, rxrdy;

    assign in_ch = !addr_i[2];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_me;
        assign sel_me = in_ch && (addr_i[3] == 1'(g));
        assign txrdy[g] = ch_lvl_i[g*LVLW + 2];
        assign rxrdy[g] = ch_lvl_i[g*LVLW + 0];

        uart_fe_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_i && sel_me),
            .rd_i      (rd_i && sel_me),
            .off_i     (addr_i[1:0]),
            .wdata_i   (wdata_i),
            .lvl_i     (ch_lvl_i[g*LVLW +: LVLW]),
            .err_i     (ch_err_i[g*LVLW +: LVLW]),
            .brkchg_i  (ch_brkchg_i[g]),
            .rx_char_i (rx_char_i[g*DW +: DW]),
            .mr1_o     (mode1_o[g*DW +: DW]),
            .mr2_o     (mode2_o[g*DW +: DW]),
            .csr_o     (clksel_o[g*DW +: DW]),
            .tx_en_o   (tx_en_o[g]),
            .rx_en_o   (rx_en_o[g]),
            .brk_o     (brk_o[g]),
            .tx_load_o (tx_load_o[g]),
            .tx_char_o (tx_char_o[g*DW +: DW]),
            .rx_pop_o  (rx_pop_o[g]),
            .rx_rst_o  (rx_rst_o[g]),
            .tx_rst_o  (tx_rst_o[g]),
            .brkchg_o  (brkchg_q[g]),
            .rdata_o   (ch_rdata[g])
        );
    end

    uart_fe_shared #(.IP_W(IP_W)) u_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_i && !in_ch),
        .rd_i       (rd_i && !in_ch),
        .sel_i      ({addr_i[3], addr_i[1:0]}),
        .wdata_i    (wdata_i),
        .txrdy_i    (txrdy),
        .rxrdy_i    (rxrdy),
        .brkchg_i   (brkchg_q),
        .ct_done_i  (ct_done_i),
        .ct_count_i (ct_count_i),
        .ip_i       (ip_i),
        .acr_o      (aux_ctl_o),
        .opcr_o     (op_cfg_o),
        .op_o       (op_o),
        .preload_o  (ct_preload_o),
        .ct_start_o (ct_start_o),
        .ct_stop_o  (ct_stop_o),
        .irq_o      (irq_o),
        .rdata_o    (sh_rdata)
    );

    // Final read mux between channel space and shared space.
    assign rdata_o = in_ch ? ch_rdata[addr_i[3]] : sh_rdata;

    AST_CH_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && in_ch && !addr_i[3]) |=> $stable(mode1_o[15:8])); // R12

endmodule

// File: tb/uart_fe_bench.sv
`timescale 1ns/1ps
module uart_fe_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  ch_lvl = '0, ch_err = '0;
    logic [1:0]  ch_brkchg = '0;
    logic [15:0] rx_char = '0;
    logic        ct_done = 1'b0;
    logic [15:0] ct_count = '0;
    logic [5:0]  ip = '0;
    logic [15:0] mode1, mode2, clksel, tx_char, preload;
    logic [1:0]  tx_en, rx_en, brk, tx_load, rx_pop, rx_rst, tx_rst;
    logic [7:0]  aux_ctl, op_cfg, op;
    logic        ct_start, ct_stop, irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    uart_fe u_uart_fe (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .ch_lvl_i(ch_lvl), .ch_err_i(ch_err),
        .ch_brkchg_i(ch_brkchg), .rx_char_i(rx_char), .ct_done_i(ct_done),
        .ct_count_i(ct_count), .ip_i(ip), .mode1_o(mode1), .mode2_o(mode2),
        .clksel_o(clksel), .tx_en_o(tx_en), .rx_en_o(rx_en), .brk_o(brk),
        .tx_load_o(tx_load), .tx_char_o(tx_char), .rx_pop_o(rx_pop),
        .rx_rst_o(rx_rst), .tx_rst_o(tx_rst), .aux_ctl_o(aux_ctl),
        .op_cfg_o(op_cfg), .op_o(op), .ct_preload_o(preload),
        .ct_start_o(ct_start), .ct_stop_o(ct_stop), .irq_o(irq)
    );

    // Vector: {is_read, addr[3:0], wdata[7:0], expect[7:0]}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'h0, 8'h13, 8'h00},  // R2 write MR1 A
        {1'b0, 4'h0, 8'h07, 8'h00},  // R2 write MR2 A
        {1'b1, 4'h0, 8'h00, 8'h07},  // R2 pointer stays on MR2
        {1'b0, 4'h2, 8'h10, 8'h00},  // R2 pointer reset
        {1'b1, 4'h0, 8'h00, 8'h13},  // R2 MR1 after reset
        {1'b1, 4'h0, 8'h00, 8'h07},  // R2 then MR2
        {1'b0, 4'hC, 8'hA5, 8'h00},  // R11 vector write
        {1'b1, 4'hC, 8'h00, 8'hA5},  // R11 vector read
        {1'b0, 4'h8, 8'h1F, 8'h00},  // R12 MR1 B
        {1'b1, 4'h8, 8'h00, 8'h00},  // R12 MR2 B still zero
        {1'b0, 4'hA, 8'h10, 8'h00},  // R12 pointer reset B
        {1'b1, 4'h8, 8'h00, 8'h1F},  // R12 MR1 B
        {1'b1, 4'h0, 8'h00, 8'h07}   // R12 channel A untouched
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 mode1", mode1, 0);
        chk("R1 enables", {tx_en, rx_en, brk}, 0);
        chk("R1 op", op, 0);
        do_rd(4'hC, d); chk("R1 vector", d, 8'h0F);
        do_rd(4'h5, d); chk("R1 int status", d, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                do_rd(VEC[i][19:16], d);
                chk($sformatf("vector %0d", i), d, VEC[i][7:0]);
            end else begin
                do_wr(VEC[i][19:16], VEC[i][15:8]);
            end
        end
        chk("R2 mode1 A port", mode1[7:0], 8'h13);
        chk("R12 mode1 B port", mode1[15:8], 8'h1F);

        // R3 status / clock select / buffers
        ch_lvl = 8'h0C;
        do_rd(4'h1, d); chk("R3 status read", d, 8'h0C);
        do_wr(4'h1, 8'h66); chk("R3 clksel", clksel[7:0], 8'h66);
        do_rd(4'h1, d); chk("R3 status after csr write", d, 8'h0C);
        do_wr(4'h3, 8'h5A);
        chk("R3 load strobe", tx_load, 2'b01);
        chk("R3 tx char", tx_char[7:0], 8'h5A);
        @(negedge clk); chk("R3 load strobe ends", tx_load, 2'b00);
        rx_char = 16'h77C3;
        do_rd(4'h3, d); chk("R3 rx char", d, 8'hC3);
        chk("R3 pop strobe", rx_pop, 2'b01);
        @(negedge clk); chk("R3 pop strobe ends", rx_pop, 2'b00);

        // R4 enables
        do_wr(4'h2, 8'h05); chk("R4 enable both", {tx_en[0], rx_en[0]}, 2'b11);
        do_wr(4'h2, 8'h0A); chk("R4 disable both", {tx_en[0], rx_en[0]}, 2'b00);
        do_wr(4'h2, 8'h05);
        do_wr(4'h2, 8'h0F); chk("R4 disable wins", {tx_en[0], rx_en[0]}, 2'b00);
        do_wr(4'h2, 8'h04); chk("R4 tx only", {tx_en[0], rx_en[0]}, 2'b10);

        // R5 one-shot commands and break
        do_wr(4'h2, 8'h20); chk("R5 rx reset strobe", {rx_rst, tx_rst}, 4'b0100);
        @(negedge clk); chk("R5 rx reset ends", rx_rst, 2'b00);
        do_wr(4'h2, 8'h30); chk("R5 tx reset strobe", {rx_rst, tx_rst}, 4'b0001);
        do_wr(4'h2, 8'h60); chk("R5 break on", brk, 2'b01);
        chk("R12 break B unaffected", brk[1], 1'b0);
        do_wr(4'h2, 8'h70); chk("R5 break off", brk, 2'b00);
        chk("R5 tx enable held", tx_en[0], 1'b1);

        // R6 sticky errors
        @(negedge clk); ch_err = 8'h06;
        @(negedge clk); ch_err = 8'h00;
        do_rd(4'h1, d); chk("R6 sticky errors", d, 8'h6C);
        do_rd(4'h9, d); chk("R12 B status clean", d, 8'h00);
        do_wr(4'h2, 8'h40);
        do_rd(4'h1, d); chk("R6 error clear", d, 8'h0C);

        // R7 interrupt status and mask
        ch_lvl = 8'h01;
        do_wr(4'h5, 8'h02); chk("R7 irq rx ready A", irq, 1'b1);
        do_rd(4'h5, d); chk("R7 status", d, 8'h02);
        do_wr(4'h5, 8'h20); chk("R7 masked other", irq, 1'b0);
        @(negedge clk); ch_brkchg = 2'b01;
        @(negedge clk); ch_brkchg = 2'b00;
        do_wr(4'h5, 8'h04); chk("R7 break change irq", irq, 1'b1);
        do_rd(4'h5, d); chk("R7 status break", d, 8'h06);
        do_wr(4'h2, 8'h50); chk("R7 break ack", irq, 1'b0);

        // R9 counter/timer
        ch_lvl = 8'h00;
        do_wr(4'h6, 8'h12);
        do_wr(4'h7, 8'h34); chk("R9 preload", preload, 16'h1234);
        ct_count = 16'hBEEF;
        do_rd(4'h6, d); chk("R9 count hi", d, 8'hBE);
        do_rd(4'h7, d); chk("R9 count lo", d, 8'hEF);
        do_rd(4'hE, d); chk("R9 start strobe", {ct_start, ct_stop}, 2'b10);
        @(negedge clk); ct_done = 1'b1;
        @(negedge clk); ct_done = 1'b0;
        do_wr(4'h5, 8'h08); chk("R9 timer irq", irq, 1'b1);
        do_rd(4'hF, d); chk("R9 stop strobe", {ct_start, ct_stop}, 2'b01);
        chk("R9 timer cleared", irq, 1'b0);

        // R8 output port
        do_wr(4'hE, 8'h81); chk("R8 set", op, 8'h81);
        do_wr(4'hE, 8'h10); chk("R8 set keeps", op, 8'h91);
        do_wr(4'hF, 8'h01); chk("R8 clear", op, 8'h90);

        // R10 input change
        @(negedge clk); ip = 6'b100010;
        do_rd(4'h5, d); chk("R10 change in status", d, 8'h80);
        do_rd(4'hD, d); chk("R10 raw pins", d, 8'h22);
        do_rd(4'h4, d); chk("R10 change register", d, 8'h22);
        do_rd(4'h4, d); chk("R10 change cleared", d, 8'h02);

        // R11 auxiliary and output configuration
        do_wr(4'h4, 8'h80); chk("R11 aux ctl", aux_ctl, 8'h80);
        do_wr(4'hD, 8'h04); chk("R11 op cfg", op_cfg, 8'h04);
        do_rd(4'hC, d); chk("R11 vector kept", d, 8'hA5);

        summary();
    end

endmodule